// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a bus-programmed watchdog with two escalation stages. An interval counter advances one step per clock while the watchdog runs and wraps every 2^N cycles. The first wrap raises a state flag that is also driven out as a level interrupt. Software services the watchdog by writing a one to a status bit. If software does not do this and the counter wraps again while the state flag is still set, the block issues a one-cycle reset request and latches a reset-status flag. The first interrupt therefore comes after one interval and the reset request after two.

Software sees three 32-bit words through a plain register port. Two words are control/status and the third is a read-only timebase counter that runs freely and never stops. The run permission is split across two bits in two different words. Either bit keeps the watchdog counting. Both must be cleared, by two separate writes, before the watchdog halts and its interval count returns to zero.

Top module: `wdog_two_stage`

## Requirements
- R1: After the asynchronous bus reset, both control/status words read 0, `irq_o` is low and `wdt_rst_o` is low.
- R2: Word addresses are byte offsets 0x0 (control/status A), 0x4 (control/status B) and 0x8 (timebase). In word A, bit 1 is run-enable A (read/write), bit 2 is the state flag and bit 3 is the reset-status flag. In word B, bit 0 is run-enable B (read/write). All other bits of A and B read as 0.
- R3: The interval counter advances while either run-enable bit is 1. When both are 0 it holds at zero, so counting restarts from zero after the watchdog is enabled again.
- R4: Counting starts on the clock edge that enables it. 2^N edges later the state flag sets and `irq_o` rises.
- R5: If the counter wraps while the state flag is already set, `wdt_rst_o` is high for exactly one cycle and the reset-status flag sets on that same edge. The state flag stays set.
- R6: Writing word A with bit 2 equal to 1 clears the state flag. Writing word A with bit 3 equal to 1 clears the reset-status flag. Either write restarts the interval count from zero.
- R7: Writing 0 to bit 2 or bit 3 of word A leaves the corresponding flag unchanged.
- R8: The timebase word increments by one on every clock edge, whether or not the watchdog runs.
- R9: `irq_o` follows the state flag and goes low on the edge of the write that clears it.
- R10: The reset-status flag stays set after the reset pulse ends, until a write clears it or the bus reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low bus reset |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | First-stage interrupt level |
| wdt_rst_o | output | 1 | Second-stage reset request, one-cycle pulse |

## Verification
The hardest behaviour to reach from the ports is an escalation to reset that software could have prevented by servicing, and a service write that lands exactly where an overflow would otherwise occur. The bench reaches the first case by leaving the watchdog unserviced and counting edges exactly to both wraps. It reaches the second with random service gaps of up to a full interval minus one cycle, and it switches between the two status bits used for service. Halting is tested by disabling the watchdog partway through an interval and checking that the next interrupt comes a full interval after it is enabled again, not sooner.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // word index = byte address / 4
    localparam int unsigned WORD_CSA = 0;
    localparam int unsigned WORD_CSB = 1;
    localparam int unsigned WORD_TB  = 2;

    // bit positions in control/status A
    localparam int unsigned CSA_EN_BIT  = 1;
    localparam int unsigned CSA_WDS_BIT = 2;
    localparam int unsigned CSA_WRS_BIT = 3;
    // bit position in control/status B
    localparam int unsigned CSB_EN_BIT  = 0;

    typedef struct packed {
        logic en_a;
        logic en_b;
        logic state_flag;
        logic rst_flag;
        logic rst_pulse;
    } ctrl_t;

endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int unsigned TB_W = 32
) (
    input  logic            clk,
    input  logic            arst_n,
    output logic [TB_W-1:0] tb_o
);
    logic [TB_W-1:0] tb_d, tb_q;

    always_comb begin
        tb_d = tb_q + TB_W'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) tb_q <= '0;
        else         tb_q <= tb_d;
    end

    assign tb_o = tb_q;

    // R8: free-running, steps by one each edge
    p_tb_step_r8: assert property (@(posedge clk) disable iff (!arst_n)
        $past(arst_n) |-> tb_q == $past(tb_q) + TB_W'(1));

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
    parameter int unsigned INTV_EXP = 30
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic ovf_o
);
    logic [INTV_EXP-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i || restart_i) cnt_d = '0;
        else                     cnt_d = cnt_q + INTV_EXP'(1);
        ovf_o = run_i && !restart_i && (&cnt_q);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R3: halted watchdog holds a zero count
    p_halt_clears_r3: assert property (@(posedge clk) disable iff (!arst_n)
        !run_i |=> cnt_q == '0);

    // R6: service restarts the count
    p_restart_r6: assert property (@(posedge clk) disable iff (!arst_n)
        restart_i |=> cnt_q == '0);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned TB_W   = 32
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [TB_W-1:0]   tb_i,
    input  logic              ovf_i,
    output logic              run_o,
    output logic              restart_o,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    ctrl_t d, q;
    logic [WORD_W-1:0] word;
    logic wr_a, wr_b, clr_state, clr_rst;

    assign word = bus_addr[ADDR_W-1:2];

    always_comb begin
        wr_a      = bus_wr && (word == WORD_W'(WORD_CSA));
        wr_b      = bus_wr && (word == WORD_W'(WORD_CSB));
        clr_state = wr_a && bus_wdata[CSA_WDS_BIT];
        clr_rst   = wr_a && bus_wdata[CSA_WRS_BIT];

        d = q;
        if (wr_a) d.en_a = bus_wdata[CSA_EN_BIT];
        if (wr_b) d.en_b = bus_wdata[CSB_EN_BIT];
        if (clr_state) d.state_flag = 1'b0;
        if (clr_rst)   d.rst_flag   = 1'b0;
        d.rst_pulse = ovf_i && q.state_flag;
        if (ovf_i) d.state_flag = 1'b1;
        if (ovf_i && q.state_flag) d.rst_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (word == WORD_W'(WORD_CSA)) begin
            bus_rdata[CSA_EN_BIT]  = q.en_a;
            bus_rdata[CSA_WDS_BIT] = q.state_flag;
            bus_rdata[CSA_WRS_BIT] = q.rst_flag;
        end else if (word == WORD_W'(WORD_CSB)) begin
            bus_rdata[CSB_EN_BIT] = q.en_b;
        end else if (word == WORD_W'(WORD_TB)) begin
            bus_rdata = DATA_W'(tb_i);
        end
    end

    assign run_o     = q.en_a || q.en_b;
    assign restart_o = clr_state || clr_rst;
    assign irq_o     = q.state_flag;
    assign wdt_rst_o = q.rst_pulse;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    // R4: first overflow raises the interrupt
    p_first_ovf_r4: assert property (@(posedge clk) disable iff (!arst_n)
        ovf_i |=> irq_o);

    // R5: reset pulse lasts one cycle and requires a prior flag
    p_rst_one_cycle_r5: assert property (@(posedge clk) disable iff (!arst_n)
        wdt_rst_o |=> !wdt_rst_o);
    p_rst_needs_flag_r5: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(wdt_rst_o) |-> $past(irq_o));

    // R10: status flag is set while the pulse is out
    p_rst_status_r10: assert property (@(posedge clk) disable iff (!arst_n)
        wdt_rst_o |-> q.rst_flag);

    // R7: a zero in the state bit keeps a set flag
    p_zero_write_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_a && !bus_wdata[CSA_WDS_BIT] && q.state_flag) |=> q.state_flag);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned TB_W     = 32,
    parameter int unsigned INTV_EXP = 30
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    logic [TB_W-1:0] tb_w;
    logic run_w, restart_w, ovf_w;

    wdog_timebase #(.TB_W(TB_W)) u_tb (
        .clk(clk), .arst_n(arst_n), .tb_o(tb_w)
    );

    wdog_interval #(.INTV_EXP(INTV_EXP)) u_intv (
        .clk(clk), .arst_n(arst_n), .run_i(run_w),
        .restart_i(restart_w), .ovf_o(ovf_w)
    );

    wdog_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TB_W(TB_W)) u_ctrl (
        .clk(clk), .arst_n(arst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_i(tb_w),
        .ovf_i(ovf_w), .run_o(run_w), .restart_o(restart_w),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    // R3: no overflow while halted
    p_no_ovf_halted_r3: assert property (@(posedge clk) disable iff (!arst_n)
        !run_w |-> !ovf_w);

endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
    localparam int unsigned N    = 4;
    localparam int unsigned INTV = 1 << N;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, wdt_rst_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    wdog_two_stage #(.INTV_EXP(N)) u_dut (
        .clk(clk), .arst_n(arst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] csa(input bit rs, input bit st, input bit en);
        return {28'd0, rs, st, en, 1'b0};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, t0, t1;
        void'($urandom(32'd4242));
        edges(2);
        @(negedge clk) arst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); chk("R1 csa", v, 32'h0);
        rd(4'h4, v); chk("R1 csb", v, 32'h0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 rst", {31'd0, wdt_rst_o}, 32'd0);

        // R4/R5: start with enable A, never serviced
        wr(4'h0, 32'hE);
        edges(INTV - 1); chk("R4 irq before interval", {31'd0, irq_o}, 32'd0);
        edges(1);        chk("R4 irq at interval", {31'd0, irq_o}, 32'd1);
        edges(INTV - 1); chk("R5 no reset before second wrap", {31'd0, wdt_rst_o}, 32'd0);
        edges(1);        chk("R5 reset at second wrap", {31'd0, wdt_rst_o}, 32'd1);
        edges(1);        chk("R5 reset one cycle", {31'd0, wdt_rst_o}, 32'd0);
        chk("R5 irq held", {31'd0, irq_o}, 32'd1);
        rd(4'h0, v); chk("R10 R2 flags after pulse", v, csa(1, 1, 1));

        // R7 zero in status bits
        wr(4'h0, 32'h2);
        rd(4'h0, v); chk("R7 zero write keeps flags", v, csa(1, 1, 1));

        // R6/R9 clear state flag, then reset-status flag with restart
        wr(4'h0, 32'h6);
        chk("R9 irq drops on clear", {31'd0, irq_o}, 32'd0);
        wr(4'h0, 32'hA);
        edges(INTV - 1); chk("R6 restart by bit3 irq low", {31'd0, irq_o}, 32'd0);
        edges(1);        chk("R6 restart by bit3 irq high", {31'd0, irq_o}, 32'd1);
        rd(4'h0, v); chk("R6 flags after clears", v, csa(0, 1, 1));

        // R3 halt with both enables off
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0);
        edges(3 * INTV);
        chk("R3 halted no reset", {31'd0, wdt_rst_o}, 32'd0);
        rd(4'h0, v); chk("R3 R7 halted flags", v, csa(0, 1, 0));
        wr(4'h0, 32'h4);
        rd(4'h0, v); chk("R6 cleared while halted", v, 32'h0);

        // R3 enable B alone counts
        wr(4'h4, 32'h1);
        edges(INTV - 1); chk("R3 enB irq low", {31'd0, irq_o}, 32'd0);
        edges(1);        chk("R3 enB irq high", {31'd0, irq_o}, 32'd1);
        rd(4'h4, v); chk("R2 csb readback", v, 32'h1);
        rd(4'h4, v); v = 32'h1;

        // R3 halting mid-interval clears the count
        wr(4'h0, 32'h4);
        edges(10);
        wr(4'h4, 32'h0);
        edges(2 * INTV);
        chk("R3 halted irq low", {31'd0, irq_o}, 32'd0);
        wr(4'h4, 32'h1);
        edges(INTV - 1); chk("R3 count cleared irq low", {31'd0, irq_o}, 32'd0);
        edges(1);        chk("R3 count cleared irq high", {31'd0, irq_o}, 32'd1);

        // R6 random service gaps keep the watchdog quiet
        wr(4'h0, 32'h6);
        for (int k = 0; k < 40; k++) begin
            int g;
            logic [31:0] kick;
            g = $urandom_range(1, INTV - 1);
            case ($urandom_range(0, 2))
                0: kick = 32'h6;
                1: kick = 32'hA;
                default: kick = 32'hE;
            endcase
            if (g > 1) edges(g - 1);
            wr(4'h0, kick);
            chk("R6 serviced irq low", {31'd0, irq_o}, 32'd0);
        end
        chk("R6 serviced no reset", {31'd0, wdt_rst_o}, 32'd0);

        // R8 timebase deltas
        for (int k = 0; k < 8; k++) begin
            int d;
            d = $urandom_range(0, 20);
            rd(4'h8, t0);
            for (int j = 0; j < d; j++) @(negedge clk);
            rd(4'h8, t1);
            chk("R8 timebase delta", t1 - t0, 32'(d + 1));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule